// File: doc/BRIEF.md
# Register-Controlled GPIO Port with Hardware Blink

This block is a 32-pin general-purpose I/O port controlled by software over a simple register interface. A write is one cycle: a strobe, a byte address and a data word. Reads return the addressed register with no clock in between. Each pin has four control bits: a level to drive, a direction, a blink enable and an input inversion. The block drives the pad output value and output enable, and returns each pad level after resynchronising it.

An output pin with blink enabled does not drive its stored level. It drives a square wave that all blinking pins share. The wave comes from one free-running counter and changes state every `HALF_CYCLES` clocks, so an LED can flash with no software involved. Pins that a build does not use are fixed as outputs driven low, whatever software writes. Interrupt detection and any bus protocol bridge sit in neighbouring blocks.

Top module: `gpio_blink_port`

## Requirements
- R1: During and after reset, every used pin is an input with its output enable low. The direction register reads all used bits as 1, and the level, blink and inversion registers read 0. `pad_out` is 0.
- R2: A write with `wr_en` high updates the register selected by `addr[4:2]` at the next rising edge. The selections are level 0, direction 1, blink 2 and inversion 3. The new value is readable on `rdata` in the cycle that follows, with no added latency. `addr[1:0]` is ignored.
- R3: A direction bit of 1 turns the pin's output enable off. A direction bit of 0 turns it on.
- R4: Reading `addr[4:2]`=4 returns the resynchronised pad level XOR the inversion bit. A pad change appears there after the second rising edge that follows it. An inversion write takes effect in the next cycle.
- R5: On a pin whose blink bit is 0, `pad_out` equals the stored level bit.
- R6: On a pin whose blink bit is 1, `pad_out` follows a square wave that changes state every `HALF_CYCLES` clocks. All blinking pins are in phase. The wave first goes high when the shared counter first wraps.
- R7: Writes to `addr[4:2]` values 4 to 7 change no register. Reads of values 5 to 7 return 0.
- R8: A pin whose `USED_MASK` bit is 0 is always an output driven low. All of its register bits, including the input bit, read 0, and writes do not change them.
- R9: Clearing a blink bit gives the pin back its stored level in the next cycle. While the blink bit is set, the wave overrides the stored level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, active low, asserted asynchronously and deasserted in step with `clk` |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 5 | Byte address; bits 4:2 select the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables, 1 means driving |

## Verification
The hardest behaviour to reach is the blink timing: the period of the shared wave and the phase match between pins. The counter runs freely from reset and no port can read it. The stimulus therefore turns blink on for two output pins and records the cycle of each level change seen on `pad_out`. It then checks that the gap between consecutive changes is exactly `HALF_CYCLES` and that both pins always show the same level. The two-edge latency of the input path is checked cycle by cycle around a pad change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Register selection codes carried on addr[4:2]
  localparam int unsigned SEL_LEVEL  = 0;
  localparam int unsigned SEL_DIR    = 1;
  localparam int unsigned SEL_BLINK  = 2;
  localparam int unsigned SEL_INV    = 3;
  localparam int unsigned SEL_SENSE  = 4;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] stab_q, stab_d;

  always_comb begin
    meta_d = raw_i;
    stab_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
  parameter int unsigned HALF_CYCLES = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase_o
);
  localparam int unsigned CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;
  logic          wrap;

  always_comb begin
    wrap    = (cnt_q == LAST);
    cnt_d   = wrap ? '0 : cnt_q + CW'(1);
    phase_d = wrap ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R6
  wrap_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_q) |-> $past(cnt_q) == LAST);
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int unsigned           WIDTH = 32,
  parameter int unsigned           SEL_W = 3,
  parameter logic [WIDTH-1:0]      USED  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] sense_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] blink_o,
  output logic [WIDTH-1:0] inv_o,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] level_q, level_d;
  logic [WIDTH-1:0] dir_q,   dir_d;
  logic [WIDTH-1:0] blink_q, blink_d;
  logic [WIDTH-1:0] inv_q,   inv_d;
  logic             en_level, en_dir, en_blink, en_inv;
  logic [WIDTH-1:0] wmask;

  always_comb begin
    wmask    = wdata & USED;
    en_level = wr_en && (sel == SEL_W'(SEL_LEVEL));
    en_dir   = wr_en && (sel == SEL_W'(SEL_DIR));
    en_blink = wr_en && (sel == SEL_W'(SEL_BLINK));
    en_inv   = wr_en && (sel == SEL_W'(SEL_INV));
    level_d  = wmask;
    dir_d    = wmask;
    blink_d  = wmask;
    inv_d    = wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      dir_q   <= USED;
      blink_q <= '0;
      inv_q   <= '0;
    end else begin
      if (en_level) level_q <= level_d;
      if (en_dir)   dir_q   <= dir_d;
      if (en_blink) blink_q <= blink_d;
      if (en_inv)   inv_q   <= inv_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_W'(SEL_LEVEL): rdata = level_q;
      SEL_W'(SEL_DIR):   rdata = dir_q;
      SEL_W'(SEL_BLINK): rdata = blink_q;
      SEL_W'(SEL_INV):   rdata = inv_q;
      SEL_W'(SEL_SENSE): rdata = sense_i;
      default:           rdata = '0;
    endcase
  end

  assign level_o = level_q;
  assign dir_o   = dir_q;
  assign blink_o = blink_q;
  assign inv_o   = inv_q;

  // R2
  level_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_level |=> level_q == $past(wdata & USED));
  // R7
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel >= SEL_W'(SEL_SENSE)) |=>
      ($stable(level_q) && $stable(dir_q) && $stable(blink_q) && $stable(inv_q)));
endmodule

// File: rtl/gpio_blink_port.sv
module gpio_blink_port #(
  parameter int unsigned      WIDTH       = 32,
  parameter int unsigned      ADDR_W      = 5,
  parameter int unsigned      HALF_CYCLES = 12_500_000,
  parameter logic [WIDTH-1:0] USED_MASK   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);
  localparam int unsigned SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0] sel;
  logic [1:0]       unused_byte_lane;
  logic [WIDTH-1:0] pad_sync, sense;
  logic [WIDTH-1:0] level, dir, blink, inv;
  logic             phase;

  assign sel              = addr[ADDR_W-1:2];
  assign unused_byte_lane = addr[1:0];

  gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pad_in),
    .sync_o (pad_sync)
  );

  assign sense = (pad_sync ^ inv) & USED_MASK;

  gpio_port_regs #(.WIDTH(WIDTH), .SEL_W(SEL_W), .USED(USED_MASK)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .sel     (sel),
    .wdata   (wdata),
    .sense_i (sense),
    .level_o (level),
    .dir_o   (dir),
    .blink_o (blink),
    .inv_o   (inv),
    .rdata   (rdata)
  );

  gpio_blink_gen #(.HALF_CYCLES(HALF_CYCLES)) u_blink (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_o (phase)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pad_out[i] = blink[i] ? phase : level[i];
    assign pad_oe[i]  = ~dir[i];
  end

  // R8
  unused_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~USED_MASK) == ~USED_MASK) && ((pad_out & ~USED_MASK) == '0));
endmodule

// File: tb/gpio_blink_port_tb.sv
module gpio_blink_port_tb;
  localparam int unsigned HALF = 6;
  localparam logic [31:0] USED = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  typedef struct {
    int          what;   // 0 rdata, 1 pad_out, 2 pad_oe
    logic [31:0] exp;
    logic [31:0] mask;
    string       req;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  gpio_blink_port #(.HALF_CYCLES(HALF), .USED_MASK(USED)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic void check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  // monitor: pops scoreboard entries and compares them with the live outputs
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      logic [31:0] v;
      e = sb.pop_front();
      case (e.what)
        0:       v = rdata;
        1:       v = pad_out;
        default: v = pad_oe;
      endcase
      check(e.req, v & e.mask, e.exp & e.mask);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic expect_item(input int what, input logic [4:0] a,
                             input logic [31:0] e, input logic [31:0] m,
                             input string req);
    exp_t it;
    addr = a;
    it.what = what; it.exp = e; it.mask = m; it.req = req;
    sb.push_back(it);
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string req);
    expect_item(0, a, e, 32'hFFFF_FFFF, req);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(5'h04, USED, "R1");
    rd(5'h00, 32'h0, "R1");
    rd(5'h08, 32'h0, "R1");
    rd(5'h0C, 32'h0, "R1");
    expect_item(2, 5'h00, ~USED, 32'hFFFF_FFFF, "R1");
    expect_item(1, 5'h00, 32'h0, 32'hFFFF_FFFF, "R1");

    // R2 / R5 level register, byte-lane bits ignored
    wr(5'h03, 32'hA5A5_5A5A);
    rd(5'h00, 32'h05A5_5A5A, "R2");
    expect_item(1, 5'h00, 32'h05A5_5A5A, 32'hFFFF_FFFF, "R5");

    // R3 direction
    wr(5'h04, 32'hFFFF_0000);
    rd(5'h04, 32'h0FFF_0000, "R3");
    expect_item(2, 5'h00, 32'hF000_FFFF, 32'hFFFF_FFFF, "R3");

    // R4 two-edge latency, then inversion
    pad_in = 32'h1234_5678;
    rd(5'h10, 32'h0, "R4");
    rd(5'h10, 32'h0, "R4");
    rd(5'h10, 32'h0234_5678, "R4");
    wr(5'h0C, 32'h0000_FFFF);
    rd(5'h10, 32'h0234_A987, "R4");

    // R7 writes to input and unmapped selections ignored
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h00, 32'h05A5_5A5A, "R7");
    rd(5'h04, 32'h0FFF_0000, "R7");
    rd(5'h08, 32'h0, "R7");
    rd(5'h0C, 32'h0000_FFFF, "R7");
    rd(5'h10, 32'h0234_A987, "R7");
    rd(5'h14, 32'h0, "R7");
    rd(5'h18, 32'h0, "R7");

    // R6 shared blink wave
    wr(5'h04, 32'h0);
    wr(5'h00, 32'h0000_000F);
    wr(5'h08, 32'h0000_0003);
    begin
      int last = -1;
      int seen = 0;
      logic prev;
      prev = pad_out[0];
      for (int c = 0; c < 60 && seen < 4; c++) begin
        @(negedge clk);
        check("R6", {31'h0, pad_out[1]}, {31'h0, pad_out[0]});
        check("R5", {30'h0, pad_out[3:2]}, 32'h3);
        if (pad_out[0] !== prev) begin
          if (last >= 0) check("R6", 32'(c - last), 32'(HALF));
          last = c;
          prev = pad_out[0];
          seen++;
        end
      end
      check("R6", 32'(seen), 32'd4);
      @(posedge clk); #1;
    end

    // R9 clearing blink restores level; blink overrides a low level
    wr(5'h08, 32'h0);
    expect_item(1, 5'h00, 32'h0000_000F, 32'h0000_000F, "R9");
    wr(5'h00, 32'h0);
    wr(5'h08, 32'h0000_0004);
    begin
      bit hi = 0;
      for (int c = 0; c < 2 * HALF + 2; c++) begin
        @(negedge clk);
        if (pad_out[2] === 1'b1) hi = 1;
      end
      check("R9", {31'h0, hi}, 32'h1);
      @(posedge clk); #1;
    end
    wr(5'h08, 32'h0);

    // R8 unused pins parked low as outputs
    pad_in = 32'hF234_5678;
    wr(5'h00, 32'hFFFF_FFFF);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h00, 32'h0FFF_FFFF, "R8");
    expect_item(1, 5'h00, 32'h0FFF_FFFF, 32'hFFFF_FFFF, "R8");
    rd(5'h0C, 32'h0FFF_FFFF, "R8");
    rd(5'h10, 32'h0DCB_A987, "R8");
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, 32'h0FFF_FFFF, "R8");
    expect_item(2, 5'h00, 32'hF000_0000, 32'hFFFF_FFFF, "R8");

    repeat (2) @(posedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule